// File: doc/BRIEF.md
# Octal Character Bootstrap Loader

This block turns a stream of ASCII characters, arriving one byte at a time from a tape reader or a keyboard, into words written to memory. Each octal digit character shifts three bits into an accumulator. Control characters then decide what happens to the accumulated value:

- It can become the load address.
- It can be written to memory at the current address, after which the address steps forward.
- It can be dropped when loading ends.

Because the address can be reloaded at any point, one character stream can fill several separate, non-contiguous regions of memory.

Bytes enter through a valid/ready handshake. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. Writes leave through a request/acknowledge port: `mem_req` stays high, with its address and data held, until `mem_ack` is seen. No further byte is accepted while a write is pending.

The controller has three named states:

- ACCEPT takes input bytes.
- WRITE holds a store request.
- FINISHED is entered after the end character and is left only by reset.

Its transitions are:

- ACCEPT→WRITE on an accepted CR or LF.
- WRITE→ACCEPT on `mem_ack`.
- ACCEPT→FINISHED on an accepted `$`.
- Every other case stays in the same state.

Top module: `octal_loader`

## Requirements
- R1: After reset, `in_ready` is 1, `mem_req` is 0, `load_done` is 0, `char_err` is 0, and the accumulator and the load address are both 0.
- R2: An accepted digit byte from 8'h30 to 8'h37 shifts the 18-bit accumulator left by 3 and puts the value (byte minus 8'h30) in bits 2:0. Bits shifted out above bit 17 are lost.
- R3: An accepted `/` (8'h2F) copies the low `ADDR_W` bits of the accumulator into the load address and clears the accumulator.
- R4: An accepted CR (8'h0D) or LF (8'h0A) raises `mem_req` on the next cycle, with `mem_addr` equal to the load address and `mem_data` equal to the accumulator. It also clears the accumulator.
- R5: While `mem_req` is high and `mem_ack` has not arrived, `mem_req`, `mem_addr` and `mem_data` stay unchanged and `in_ready` is 0.
- R6: On the cycle `mem_ack` is seen with `mem_req`, `mem_req` drops on the next cycle, the load address increments by one, and `in_ready` returns to 1.
- R7: A control character with no digit since the previous control character (or since reset) acts on an accumulator value of zero.
- R8: An accepted `$` (8'h24) sets `load_done`. From then until reset, `load_done` stays 1 and `in_ready` stays 0.
- R9: Accepted space (8'h20), NUL (8'h00) and rubout (8'h7F) bytes change neither the accumulator, the address nor `char_err`.
- R10: Any other accepted byte sets `char_err`, which stays set until reset. The accumulator is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is present |
| in_byte | input | 8 | ASCII character |
| in_ready | output | 1 | Block can take a byte this cycle |
| mem_req | output | 1 | Store request pending |
| mem_addr | output | ADDR_W (15) | Address of the store |
| mem_data | output | WORD_W (18) | Word to store |
| mem_ack | input | 1 | Memory has taken the store |
| load_done | output | 1 | End character received |
| char_err | output | 1 | Sticky flag for an unexpected character |

## Verification
The assertions assume that `mem_ack` is asserted only while `mem_req` is high, and for a single cycle per request. The bench memory model follows this: it raises the acknowledge on a falling edge only while a request is pending, after a programmable wait, and lowers it again one cycle later.

The assertions also assume that input bytes are offered only through the handshake. The bench drivers wait for `in_ready` before raising `in_valid`, and drop `in_valid` one edge after acceptance.

// File: rtl/loader_pkg.sv
package loader_pkg;

    typedef enum logic [1:0] {
        ST_ACCEPT,
        ST_WRITE,
        ST_FINISHED
    } ldr_state_t;

    typedef enum logic [2:0] {
        CH_DIGIT,
        CH_SETADDR,
        CH_STORE,
        CH_END,
        CH_SKIP,
        CH_BAD
    } chr_kind_t;

    localparam logic [7:0] CODE_ZERO   = 8'h30;
    localparam logic [7:0] CODE_SEVEN  = 8'h37;
    localparam logic [7:0] CODE_SLASH  = 8'h2F;
    localparam logic [7:0] CODE_CR     = 8'h0D;
    localparam logic [7:0] CODE_LF     = 8'h0A;
    localparam logic [7:0] CODE_DOLLAR = 8'h24;
    localparam logic [7:0] CODE_SPACE  = 8'h20;
    localparam logic [7:0] CODE_NUL    = 8'h00;
    localparam logic [7:0] CODE_RUBOUT = 8'h7F;

endpackage

// File: rtl/char_classifier.sv
module char_classifier
    import loader_pkg::*;
(
    input  logic [7:0] chr,
    output chr_kind_t  kind,
    output logic [2:0] digit
);

    always_comb begin
        digit = chr[2:0];
        if (chr >= CODE_ZERO && chr <= CODE_SEVEN) begin
            kind = CH_DIGIT;
        end else if (chr == CODE_SLASH) begin
            kind = CH_SETADDR;
        end else if (chr == CODE_CR || chr == CODE_LF) begin
            kind = CH_STORE;
        end else if (chr == CODE_DOLLAR) begin
            kind = CH_END;
        end else if (chr == CODE_SPACE || chr == CODE_NUL || chr == CODE_RUBOUT) begin
            kind = CH_SKIP;
        end else begin
            kind = CH_BAD;
        end
    end

endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              clear_en,
    input  logic [2:0]        digit,
    output logic [WORD_W-1:0] acc
);

    localparam int KEEP_W = WORD_W - 3;

    logic [WORD_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear_en) begin
            acc_q <= '0;
        end else if (shift_en) begin
            acc_q <= {acc_q[KEEP_W-1:0], digit};
        end
    end

    assign acc = acc_q;

    // R7: after a clear the next cycle starts from zero
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_en |=> acc == '0);

    // R9: no shift and no clear leaves the word untouched
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clear_en) |=> $stable(acc));

endmodule

// File: rtl/loader_ctrl.sv
module loader_ctrl
    import loader_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  chr_kind_t         kind,
    input  logic [WORD_W-1:0] acc,
    input  logic              mem_ack,
    output logic              in_ready,
    output logic              take,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    output logic              load_done,
    output logic              char_err
);

    ldr_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic              err_q;
    logic [ADDR_W-1:0] acc_as_addr;

    generate
        if (ADDR_W <= WORD_W) begin : g_trunc
            assign acc_as_addr = acc[ADDR_W-1:0];
        end else begin : g_pad
            assign acc_as_addr = {{(ADDR_W-WORD_W){1'b0}}, acc};
        end
    endgenerate

    assign take = in_valid && in_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACCEPT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCEPT: begin
                if (take && kind == CH_STORE) begin
                    state_d = ST_WRITE;
                end else if (take && kind == CH_END) begin
                    state_d = ST_FINISHED;
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    state_d = ST_ACCEPT;
                end
            end
            ST_FINISHED: state_d = ST_FINISHED;
            default:     state_d = ST_ACCEPT;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        load_done = 1'b0;
        unique case (state_q)
            ST_ACCEPT:   in_ready  = 1'b1;
            ST_WRITE:    mem_req   = 1'b1;
            ST_FINISHED: load_done = 1'b1;
            default:     in_ready  = 1'b0;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (state_q == ST_WRITE && mem_ack) begin
                addr_q <= addr_q + 1'b1;
            end else if (take && kind == CH_SETADDR) begin
                addr_q <= acc_as_addr;
            end
            if (take && kind == CH_STORE) begin
                data_q <= acc;
            end
            if (take && kind == CH_BAD) begin
                err_q <= 1'b1;
            end
        end
    end

    assign mem_addr = addr_q;
    assign mem_data = data_q;
    assign char_err = err_q;

    // R5: request, address and data held until acknowledged
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

    // R5: no byte taken while a store is pending
    a_r5_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !in_ready);

    // R6: acknowledge steps the address and ends the request
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (!mem_req && in_ready && mem_addr == $past(mem_addr) + 1'b1));

    // R6: acknowledge only arrives with a request (input assumption)
    a_r6_ack_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack |-> mem_req);

    // R8: end of load is permanent
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> (load_done && !in_ready));

    // R10: error flag never clears
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        char_err |=> char_err);

    // R1: at most one of the state outputs active
    a_r1_one_state: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_ready, mem_req, load_done}));

endmodule

// File: rtl/octal_loader.sv
module octal_loader
    import loader_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    input  logic              mem_ack,
    output logic              load_done,
    output logic              char_err
);

    chr_kind_t         kind;
    logic [2:0]        digit;
    logic [WORD_W-1:0] acc;
    logic              take;
    logic              shift_en;
    logic              clear_en;

    char_classifier u_class (
        .chr   (in_byte),
        .kind  (kind),
        .digit (digit)
    );

    assign shift_en = take && kind == CH_DIGIT;
    assign clear_en = take && (kind == CH_SETADDR || kind == CH_STORE || kind == CH_END);

    word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .clear_en (clear_en),
        .digit    (digit),
        .acc      (acc)
    );

    loader_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .kind      (kind),
        .acc       (acc),
        .mem_ack   (mem_ack),
        .in_ready  (in_ready),
        .take      (take),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .load_done (load_done),
        .char_err  (char_err)
    );

endmodule

// File: tb/octal_loader_test.sv
module octal_loader_test;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 18;
    localparam int ADDR_W = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_byte = 8'h00;
    logic              in_ready;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_data;
    logic              mem_ack = 1'b0;
    logic              load_done;
    logic              char_err;

    int checks_made  = 0;
    int checks_bad   = 0;
    int ack_lat      = 0;
    int wait_cnt     = 0;
    int wr_cnt       = 0;
    int rd_ptr       = 0;
    logic [ADDR_W-1:0] log_a [32];
    logic [WORD_W-1:0] log_d [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    octal_loader #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_ready  (in_ready),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_ack   (mem_ack),
        .load_done (load_done),
        .char_err  (char_err)
    );

    // memory model: acknowledge after ack_lat waiting cycles, log each write
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= ack_lat) begin
                mem_ack <= 1'b1;
                wait_cnt <= 0;
                log_a[wr_cnt % 32] <= mem_addr;
                log_d[wr_cnt % 32] <= mem_data;
                wr_cnt <= wr_cnt + 1;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks_made++;
        if (!ok) begin
            checks_bad++;
            $display("FAIL %s: actual %0o expected %0o", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_ptr = wr_cnt;
    endtask

    task automatic send(input logic [7:0] b);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_byte = b;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send(s[i]);
    endtask

    task automatic expect_write(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d, input string req);
        while (wr_cnt == rd_ptr) @(negedge clk);
        check(log_a[rd_ptr % 32] == a, {req, " addr"}, log_a[rd_ptr % 32], a);
        check(log_d[rd_ptr % 32] == d, {req, " data"}, log_d[rd_ptr % 32], d);
        rd_ptr++;
    endtask

    task automatic t_reset();
        do_reset();
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        check(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
        check(load_done == 1'b0, "R1 load_done", load_done, 0);
        check(char_err == 1'b0, "R1 char_err", char_err, 0);
        check(mem_addr == '0, "R1 mem_addr", mem_addr, 0);
    endtask

    task automatic t_segments();
        ack_lat = 3;
        send_str("1000/");
        send_str("123");
        send(8'h0D);
        check(mem_req == 1'b1, "R4 mem_req", mem_req, 1);
        check(mem_addr == 15'o1000, "R3 address", mem_addr, 15'o1000);
        check(mem_data == 18'o123, "R2 R4 data", mem_data, 18'o123);
        check(in_ready == 1'b0, "R5 in_ready", in_ready, 0);
        @(negedge clk);
        check(mem_req == 1'b1 && mem_data == 18'o123, "R5 hold", mem_data, 18'o123);
        expect_write(15'o1000, 18'o123, "R4");
        send_str("7");
        send(8'h0A);
        expect_write(15'o1001, 18'o7, "R6");
        @(negedge clk);
        check(in_ready == 1'b1 && mem_req == 1'b0, "R6 ready", in_ready, 1);
        ack_lat = 0;
        send_str("40/52");
        send(8'h0D);
        expect_write(15'o40, 18'o52, "R3");
    endtask

    task automatic t_overflow();
        send_str("7777777");
        send_str("1");
        send(8'h0D);
        expect_write(15'o41, 18'o777771, "R2 overflow");
    endtask

    task automatic t_empty();
        send(8'h0D);
        expect_write(15'o42, 18'o0, "R7 store");
        send_str("/");
        send_str("5");
        send(8'h0D);
        expect_write(15'o0, 18'o5, "R7 address");
    endtask

    task automatic t_ignore();
        send_str("2 ");
        send(8'h00);
        send(8'h7F);
        send_str("3");
        send(8'h0A);
        expect_write(15'o1, 18'o23, "R9");
        check(char_err == 1'b0, "R9 char_err", char_err, 0);
    endtask

    task automatic t_error();
        send_str("48");
        @(negedge clk);
        check(char_err == 1'b1, "R10 set", char_err, 1);
        send_str("G6");
        send(8'h0D);
        expect_write(15'o2, 18'o46, "R10 acc kept");
        check(char_err == 1'b1, "R10 sticky", char_err, 1);
    endtask

    task automatic t_done();
        send_str("77$");
        check(load_done == 1'b1, "R8 done", load_done, 1);
        check(in_ready == 1'b0, "R8 ready", in_ready, 0);
        in_valid = 1'b1;
        in_byte = 8'h0D;
        repeat (5) @(negedge clk);
        in_valid = 1'b0;
        check(load_done == 1'b1 && in_ready == 1'b0, "R8 stays", load_done, 1);
        check(wr_cnt == rd_ptr, "R8 no write", wr_cnt, rd_ptr);
        do_reset();
        check(load_done == 1'b0 && char_err == 1'b0, "R1 after reset", load_done, 0);
    endtask

    initial begin
        t_reset();
        t_segments();
        t_overflow();
        t_empty();
        t_ignore();
        t_error();
        t_done();
        $display("End of test - %0d assertions evaluated, %0d failures", checks_made, checks_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks_made++;
        checks_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks_made, checks_bad);
        $finish;
    end

endmodule